// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates addresses for one port of a synchronous memory during bursts. It holds three registers of the address width. The counter supplies the memory address. The mask splits the counter into a frozen upper field and a counting lower field. The mirror keeps the last value written into the counter. Every operation is chosen by active-low strobes sampled on the rising clock edge. The one exception is an asynchronous master reset.

A burst works as follows. The host loads a start address once, then holds the advance enable low. The counter then steps through the unmasked field. When that field runs past its top it reloads from the mirror, so the same burst repeats, and a wrap flag marks the cycle in which that happens. The same pins can also load or reset the mask. They can place the counter or the mask on the address output so the host can read it back.

Top module: `bctr_top`

## Requirements
- R1: While `rstN` is low, the counter and mirror are 0 and the mask is all ones, and this takes effect without a clock edge.
- R2: Counter load (`cntSel`=1, `cntClrN`=1, `strobeN`=0, `advN`=0) writes `addrIn` into both the counter and the mirror at the clock edge.
- R3: Increment (`cntSel`=1, `cntClrN`=1, `strobeN`=1, `advN`=0) adds the lowest set bit of the mask to the unmasked field. Counter bits where the mask is 0 do not change.
- R4: With mask bit 0 cleared, the least significant counter bit stays frozen and the counter advances by two on each increment.
- R5: On an increment whose unmasked counter bits are all ones, the unmasked bits reload from the mirror. `wrapIrq` is high during that cycle, and it is low in every cycle that is not such an increment.
- R6: Hold (`cntSel`=1, `cntClrN`=1, `strobeN`=1, `advN`=1) leaves the counter unchanged for any number of cycles.
- R7: Counter reset (`cntSel`=1, `cntClrN`=0) clears the unmasked bits of both counter and mirror and keeps the masked bits. With an all-ones mask the result is 0.
- R8: Mask reset (`cntSel`=0, `cntClrN`=0) sets the mask to all ones. Mask load (`cntSel`=0, `cntClrN`=1, `strobeN`=0, `advN`=0) writes `addrIn` into the mask.
- R9: The mask changes only through mask load, mask reset and master reset. Every counter-mode operation leaves it intact.
- R10: The mirror changes only through counter load, counter reset and master reset. Increment and hold leave it intact.
- R11: With `strobeN`=0 and `advN`=1, `addrOut` shows the counter when `cntSel`=1 and the mask when `cntSel`=0, and the counter is not altered. In all other cases `addrOut` shows the counter.
- R12: Counter reset takes priority over counter load, and mask reset takes priority over mask load. With `cntSel`=0 and `strobeN`=1, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| rstN | input | 1 | Asynchronous master reset, active low |
| cntSel | input | 1 | 1 selects counter operations, 0 selects mask operations |
| cntClrN | input | 1 | Counter or mask reset strobe, active low |
| strobeN | input | 1 | Address strobe, active low |
| advN | input | 1 | Advance enable, active low |
| addrIn | input | 16 | Address value for loads |
| addrOut | output | 16 | Memory address, or the readback value |
| wrapIrq | output | 1 | High during an increment that wraps the burst |

## Verification
Increments are tried under every contiguous low mask from width 1 to 16, and again under the same masks with bit 0 cleared. Each run starts a few steps below the top of the field, so one pass exercises plain stepping, the wrap reload and the flag edge. This separates a counter that carries into masked bits, or that ignores a cleared bit 0, from a correct one. Further sequences load a start address, clear the counter under a partial mask and then increment to a wrap. That shows whether the mirror took the cleared value. Readback, priority collisions and mask-mode no-op patterns are checked by reading both registers back through the address output.

// File: rtl/bctr_pkg.sv
package bctr_pkg;
  typedef struct packed {
    logic ldCnt;
    logic incCnt;
    logic rstCnt;
    logic ldMsk;
    logic rstMsk;
    logic rdMsk;
  } bctrStrobes_t;
endpackage

// File: rtl/bctr_ctl.sv
module bctr_ctl
  import bctr_pkg::*;
(
  input  logic         cntSel,
  input  logic         cntClrN,
  input  logic         strobeN,
  input  logic         advN,
  output bctrStrobes_t strb
);
  always_comb begin
    strb = '0;
    if (cntSel) begin
      // counter mode: clear > load > readback > increment > hold
      if (!cntClrN)               strb.rstCnt = 1'b1;
      else if (!strobeN && !advN) strb.ldCnt  = 1'b1;
      else if (!strobeN)          strb = '0;          // counter readback: no state change
      else if (!advN)             strb.incCnt = 1'b1;
    end else begin
      // mask mode: reset > load > readback, rest is a no-op
      if (!cntClrN)               strb.rstMsk = 1'b1;
      else if (!strobeN && !advN) strb.ldMsk  = 1'b1;
      else if (!strobeN)          strb.rdMsk  = 1'b1;
    end
  end
endmodule

// File: rtl/bctr_dp.sv
module bctr_dp
  import bctr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  bctrStrobes_t      strb,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              wrapIrq,
  output logic [ADDR_W-1:0] cntQ,
  output logic [ADDR_W-1:0] mskQ,
  output logic [ADDR_W-1:0] mirQ
);
  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] stepVal;
  logic [ADDR_W-1:0] unmField;
  logic [ADDR_W-1:0] incVal;
  logic [ADDR_W-1:0] clrVal;
  logic              atTop;

  // lowest set bit of the mask is the step size
  assign stepVal  = mskQ & (~mskQ + 1'b1);
  assign unmField = cntQ & mskQ;
  assign atTop    = (unmField == mskQ);
  assign incVal   = (cntQ & ~mskQ) |
                    (atTop ? (mirQ & mskQ) : ((unmField + stepVal) & mskQ));
  assign clrVal   = cntQ & ~mskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      mirQ <= '0;
    end else if (strb.rstCnt) begin
      cntQ <= clrVal;
      mirQ <= mirQ & ~mskQ;
    end else if (strb.ldCnt) begin
      cntQ <= addrIn;
      mirQ <= addrIn;
    end else if (strb.incCnt) begin
      cntQ <= incVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            mskQ <= ALL_ONES;
    else if (strb.rstMsk) mskQ <= ALL_ONES;
    else if (strb.ldMsk)  mskQ <= addrIn;
  end

  assign addrOut = strb.rdMsk ? mskQ : cntQ;
  assign wrapIrq = strb.incCnt & atTop;
endmodule

// File: rtl/bctr_top.sv
module bctr_top
  import bctr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntSel,
  input  logic              cntClrN,
  input  logic              strobeN,
  input  logic              advN,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              wrapIrq
);
  bctrStrobes_t      strb;
  logic [ADDR_W-1:0] cntQ;
  logic [ADDR_W-1:0] mskQ;
  logic [ADDR_W-1:0] mirQ;

  bctr_ctl u_ctl (
    .cntSel (cntSel),
    .cntClrN(cntClrN),
    .strobeN(strobeN),
    .advN   (advN),
    .strb   (strb)
  );

  bctr_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .addrIn (addrIn),
    .addrOut(addrOut),
    .wrapIrq(wrapIrq),
    .cntQ   (cntQ),
    .mskQ   (mskQ),
    .mirQ   (mirQ)
  );
endmodule

// File: rtl/bctr_chk.sv
module bctr_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cntSel,
  input logic              cntClrN,
  input logic              strobeN,
  input logic              advN,
  input logic [ADDR_W-1:0] addrIn,
  input logic [ADDR_W-1:0] addrOut,
  input logic              wrapIrq,
  input logic [ADDR_W-1:0] cntQ,
  input logic [ADDR_W-1:0] mskQ,
  input logic [ADDR_W-1:0] mirQ
);
  // R1: master reset state, sampled while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_state_r1: assert (cntQ == '0 && mirQ == '0 && mskQ == '1 && !wrapIrq);
    end
  end

  p_load_both_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cntSel && cntClrN && !strobeN && !advN) |=> (cntQ == $past(addrIn) && mirQ == $past(addrIn)));

  p_masked_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cntSel && cntClrN && strobeN && !advN) |=> (((cntQ ^ $past(cntQ)) & ~mskQ) == '0));

  p_wrap_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrapIrq |=> ((cntQ & mskQ) == ($past(mirQ) & mskQ)));

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cntSel && cntClrN && strobeN && advN) |=> $stable(cntQ));

  p_mask_reset_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!cntSel && !cntClrN) |=> (mskQ == '1));

  p_mask_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cntSel || (cntClrN && strobeN)) |=> $stable(mskQ));

  p_mirror_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!cntSel || (cntClrN && strobeN)) |=> $stable(mirQ));

  p_readback_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeN && advN && cntClrN) |-> (addrOut == (cntSel ? cntQ : mskQ)));
endmodule

bind bctr_top bctr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .cntSel (cntSel),
  .cntClrN(cntClrN),
  .strobeN(strobeN),
  .advN   (advN),
  .addrIn (addrIn),
  .addrOut(addrOut),
  .wrapIrq(wrapIrq),
  .cntQ   (cntQ),
  .mskQ   (mskQ),
  .mirQ   (mirQ)
);

// File: tb/tb_bctr_top.sv
module tb_bctr_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b1;
  logic         cntSel = 1'b1;
  logic         cntClrN = 1'b1;
  logic         strobeN = 1'b1;
  logic         advN = 1'b1;
  logic [W-1:0] addrIn = '0;
  wire  [W-1:0] addrOut;
  wire          wrapIrq;

  int  nChk = 0;
  int  nErr = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  bctr_top #(.ADDR_W(W)) dut (
    .clk(clk), .rstN(rstN), .cntSel(cntSel), .cntClrN(cntClrN),
    .strobeN(strobeN), .advN(advN), .addrIn(addrIn),
    .addrOut(addrOut), .wrapIrq(wrapIrq)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit sel, input bit clr, input bit stb, input bit adv, input logic [W-1:0] a);
    @(negedge clk);
    cntSel = sel; cntClrN = clr; strobeN = stb; advN = adv; addrIn = a;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doOp(input bit sel, input bit clr, input bit stb, input bit adv, input logic [W-1:0] a);
    drive(sel, clr, stb, adv, a);
    tick();
  endtask

  task automatic readMask(output logic [W-1:0] v);
    drive(1'b0, 1'b1, 1'b0, 1'b1, '0);
    v = addrOut;
  endtask

  task automatic readCnt(output logic [W-1:0] v);
    drive(1'b1, 1'b1, 1'b1, 1'b1, '0);
    v = addrOut;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChk++; nErr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v, m, st, exp, mir, step;
    bit           expIrq;

    #2 rstN = 1'b0;
    tick();
    check("R1 counter at reset", addrOut, '0);
    check("R1 irq at reset", W'(wrapIrq), '0);
    @(negedge clk) rstN = 1'b1;
    readMask(v);
    check("R1 mask at reset", v, 16'hFFFF);

    // load and hold
    doOp(1, 1, 0, 0, 16'h1234);
    check("R2 load", addrOut, 16'h1234);
    for (int i = 0; i < 3; i++) begin
      doOp(1, 1, 1, 1, 16'hFFFF);
      check("R6 hold", addrOut, 16'h1234);
    end

    // readback
    doOp(0, 1, 0, 0, 16'h00FF);
    drive(1, 1, 0, 1, 16'h0000);
    check("R11 counter readback", addrOut, 16'h1234);
    tick();
    check("R11 counter unchanged", addrOut, 16'h1234);
    readMask(v);
    check("R11 mask readback", v, 16'h00FF);
    tick();
    readCnt(v);
    check("R11 mask readback leaves counter", v, 16'h1234);

    // sweep of masks: plain and step-by-two
    for (int k = 1; k <= W; k++) begin
      for (int two = 0; two < 2; two++) begin
        if (two == 1 && k < 2) continue;
        m = W'((32'd1 << k) - 1);
        if (two == 1) m[0] = 1'b0;
        doOp(0, 1, 0, 0, m);
        readMask(v);
        check("R8 mask load", v, m);
        st  = (16'hA5C3 & ~m) | (m & ((two == 1) ? 16'hFFF8 : 16'hFFFC));
        doOp(1, 1, 0, 0, st);
        check("R2 load start", addrOut, st);
        exp  = st;
        mir  = st;
        step = m & (~m + 1'b1);
        for (int i = 0; i < 10; i++) begin
          drive(1, 1, 1, 0, 16'h5A5A);
          expIrq = ((exp & m) == m);
          check("R5 wrap flag", W'(wrapIrq), W'(expIrq));
          tick();
          if (expIrq) exp = (exp & ~m) | (mir & m);
          else        exp = (exp & ~m) | (((exp & m) + step) & m);
          check((two == 1) ? "R4 step two" : "R3 increment", addrOut, exp);
        end
      end
    end

    // counter reset under a partial mask
    doOp(0, 1, 0, 0, 16'h00FF);
    doOp(1, 1, 0, 0, 16'hABCD);
    doOp(1, 0, 1, 1, 16'h0000);
    check("R7 partial clear", addrOut, 16'hAB00);

    // mirror cleared too, then survives increments
    doOp(0, 1, 0, 0, 16'h0003);
    doOp(1, 1, 0, 0, 16'h1236);
    doOp(1, 0, 1, 1, 16'h0000);
    check("R7 clear keeps masked", addrOut, 16'h1234);
    for (int i = 0; i < 3; i++) doOp(1, 1, 1, 0, 16'h0000);
    check("R3 reach top", addrOut, 16'h1237);
    drive(1, 1, 1, 1, 16'h0000);
    check("R5 no flag on hold at top", W'(wrapIrq), '0);
    drive(1, 1, 1, 0, 16'h0000);
    check("R5 flag on wrap", W'(wrapIrq), 16'h0001);
    tick();
    check("R10 mirror cleared and kept", addrOut, 16'h1234);

    // mask reset then counter reset gives zero
    doOp(0, 0, 1, 1, 16'h0000);
    readMask(v);
    check("R8 mask reset", v, 16'hFFFF);
    doOp(1, 1, 0, 0, 16'hBEEF);
    doOp(1, 0, 1, 1, 16'h0000);
    check("R7 full clear", addrOut, 16'h0000);

    // mask untouched by counter operations
    doOp(0, 1, 0, 0, 16'h003F);
    doOp(1, 1, 0, 0, 16'h4321);
    doOp(1, 1, 1, 0, 16'h0000);
    doOp(1, 0, 1, 1, 16'h0000);
    doOp(1, 1, 1, 1, 16'h0000);
    readMask(v);
    check("R9 mask kept", v, 16'h003F);
    tick();

    // priority and mask-mode no-ops
    doOp(0, 0, 1, 1, 16'h0000);
    doOp(1, 1, 0, 0, 16'h1234);
    doOp(1, 0, 0, 0, 16'h5555);
    check("R12 clear beats load", addrOut, 16'h0000);
    doOp(0, 1, 0, 0, 16'h000F);
    doOp(0, 0, 0, 0, 16'h00F0);
    readMask(v);
    check("R12 mask reset beats load", v, 16'hFFFF);
    tick();
    doOp(1, 1, 0, 0, 16'h2468);
    doOp(0, 1, 1, 0, 16'h000F);
    doOp(0, 1, 1, 1, 16'h00FF);
    check("R12 no-op keeps counter", addrOut, 16'h2468);
    readMask(v);
    check("R12 no-op keeps mask", v, 16'hFFFF);
    tick();

    // asynchronous master reset mid-run
    doOp(0, 1, 0, 0, 16'h0007);
    doOp(1, 1, 0, 0, 16'h9999);
    @(negedge clk);
    cntSel = 1; cntClrN = 1; strobeN = 1; advN = 1;
    #1 rstN = 1'b0;
    #1 check("R1 async counter clear", addrOut, '0);
    @(negedge clk) rstN = 1'b1;
    readMask(v);
    check("R1 async mask set", v, 16'hFFFF);
    tick();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end
endmodule